// File: doc/BRIEF.md
# Manchester Stream Generator

This block replays a payload held in an on-chip memory as a serial biphase Manchester signal. A clock line runs alongside the data. Software or a neighbouring block first fills the memory through a simple write port. It then pulses `start`, giving a frame length in words and a half-period divider. Each word is sent most significant bit first, and every bit lasts exactly two half-periods of `half_div` system clocks.

The clock line is high in the first half of each bit and low in the second half. Its falling edge at mid-bit therefore marks the transition that carries the data, and its rising edge marks the bit boundary. A zero goes low then high, and a one goes high then low. As a result, the data line changes at a boundary only when two neighbouring bits are equal. When `repeat_en` is held, the block waits `gap_cycles` idle cycles after the last bit and then replays the frame from address 0.

Top module: `manch_stream_gen`

## Requirements
- R1: After reset, and whenever no frame is active, `ser_clk` is 1, `ser_data` is 0 and `busy` is 0.
- R2: Each bit lasts 2*`half_div` system clocks. `ser_clk` is 1 for the first `half_div` cycles and 0 for the last `half_div` cycles.
- R3: A 0 bit drives `ser_data` low in the first half and high in the second half. A 1 bit drives it high then low. The data line therefore always changes at the falling edge of `ser_clk`.
- R4: At a boundary between two bits inside a frame, `ser_data` changes if and only if the two bits are equal.
- R5: A frame sends memory words 0 to `frame_len`-1 in address order, bit 7 of each word first. Words are loaded through `wr_en`/`wr_addr`/`wr_data` at least one cycle before `start`.
- R6: An accepted `start` sets `busy` from the next cycle for exactly `frame_len`*16*`half_div` cycles when repeat is off. A `start` that arrives while `busy` is high is ignored.
- R7: A `start` is ignored, and `busy` stays 0, when `frame_len` is 0, `frame_len` exceeds the memory depth, or `half_div` is 0.
- R8: `frame_len`, `half_div` and `gap_cycles` are captured only when a start is accepted. Changing them during a frame does not affect that frame.
- R9: If `repeat_en` is 1 when the last bit ends, the lines idle (clock 1, data 0) for `gap_cycles` cycles with `busy` held at 1, and then the frame restarts from address 0. A gap of 0 restarts directly.
- R10: If `repeat_en` is 0 at the end of a frame or at the end of a gap, the block returns to idle and drops `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Payload memory write strobe |
| wr_addr | input | ADDR_W | Payload memory write address |
| wr_data | input | WORD_W | Payload word to write |
| start | input | 1 | Begin a frame (sampled while idle) |
| repeat_en | input | 1 | Replay the frame after the gap |
| frame_len | input | LEN_W | Words per frame (1..DEPTH) |
| half_div | input | DIV_W | System clocks per half bit (nonzero) |
| gap_cycles | input | GAP_W | Idle cycles between repeated frames |
| ser_clk | output | 1 | Companion clock line |
| ser_data | output | 1 | Manchester data line |
| busy | output | 1 | Frame or repeat gap in progress |

## Verification
Runs of equal bits (0x00, 0xFF) are mixed with alternating patterns (0xA5, 0x96) to exercise the boundary rule. A design that inserted a boundary edge between unequal bits, or omitted it between equal ones, would break the per-cycle line comparison and the explicit boundary check. The decoder in the bench reads the level just before each mid-bit clock fall. It would expose a reversed bit order, a swapped polarity or a wrong word address, including the wrap back to address 0 when frames repeat back to back with a zero gap. Starts with invalid settings, and setting changes in the middle of a frame, target a design that failed to hold its captured divider and length.

// File: rtl/mse_pkg.sv
package mse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } mse_state_e;

    typedef struct packed {
        logic clk_line;
        logic data_line;
    } mse_line_t;

    localparam mse_line_t LINE_IDLE = '{clk_line: 1'b1, data_line: 1'b0};

    // Level pair for one half of a bit: clock high early, low late;
    // data equals the bit early and its complement late.
    function automatic mse_line_t encode_half(input logic bit_val, input logic late_half);
        mse_line_t l;
        l.clk_line  = ~late_half;
        l.data_line = bit_val ^ late_half;
        return l;
    endfunction

endpackage

// File: rtl/mse_payload_ram.sv
module mse_payload_ram #(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end

endmodule

// File: rtl/mse_half_timer.sv
module mse_half_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_end
);

    logic [DIV_W-1:0] cnt;

    assign half_end = run && (cnt == div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (half_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mse_line_encoder.sv
module mse_line_encoder
    import mse_pkg::*;
(
    input  logic sending,
    input  logic bit_val,
    input  logic late_half,
    output logic ser_clk,
    output logic ser_data
);

    mse_line_t line;

    always_comb begin
        line     = sending ? encode_half(bit_val, late_half) : LINE_IDLE;
        ser_clk  = line.clk_line;
        ser_data = line.data_line;
    end

endmodule

// File: rtl/manch_stream_gen.sv
module manch_stream_gen
    import mse_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 16,
    parameter int DIV_W  = 16,
    parameter int GAP_W  = 16,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start,
    input  logic              repeat_en,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [GAP_W-1:0]  gap_cycles,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              busy
);

    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    mse_state_e        state;
    logic              late_half;
    logic [BIT_W-1:0]  bit_idx;
    logic [LEN_W-1:0]  word_idx;
    logic [LEN_W-1:0]  len_q;
    logic [DIV_W-1:0]  div_q;
    logic [GAP_W-1:0]  gap_q;
    logic [GAP_W-1:0]  gap_cnt;
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic              half_end;
    logic              start_ok;
    logic              last_bit;
    logic              last_word;

    // Address to prefetch after word idx has been taken into the shifter.
    function automatic logic [ADDR_W-1:0] addr_after(input logic [LEN_W-1:0] idx,
                                                     input logic [LEN_W-1:0] len);
        logic [LEN_W-1:0] nxt;
        nxt = idx + 1'b1;
        if (nxt == len) begin
            return '0;
        end
        return ADDR_W'(nxt);
    endfunction

    mse_payload_ram #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    mse_half_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (state == ST_SEND),
        .div      (div_q),
        .half_end (half_end)
    );

    mse_line_encoder u_enc (
        .sending   (state == ST_SEND),
        .bit_val   (shift_q[WORD_W-1]),
        .late_half (late_half),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data)
    );

    assign busy      = (state != ST_IDLE);
    assign start_ok  = (state == ST_IDLE) && start && (frame_len != '0)
                       && (frame_len <= LEN_W'(DEPTH)) && (half_div != '0);
    assign last_bit  = (bit_idx == BIT_W'(WORD_W - 1));
    assign last_word = (word_idx == len_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            late_half <= 1'b0;
            bit_idx   <= '0;
            word_idx  <= '0;
            len_q     <= '0;
            div_q     <= '0;
            gap_q     <= '0;
            gap_cnt   <= '0;
            shift_q   <= '0;
            rd_addr   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        div_q     <= half_div;
                        len_q     <= frame_len;
                        gap_q     <= gap_cycles;
                        shift_q   <= rd_word;
                        rd_addr   <= addr_after('0, frame_len);
                        word_idx  <= '0;
                        bit_idx   <= '0;
                        late_half <= 1'b0;
                        state     <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (half_end) begin
                        if (!late_half) begin
                            late_half <= 1'b1;
                        end else begin
                            late_half <= 1'b0;
                            if (!last_bit) begin
                                bit_idx <= bit_idx + 1'b1;
                                shift_q <= shift_q << 1;
                            end else begin
                                bit_idx <= '0;
                                if (!last_word) begin
                                    word_idx <= word_idx + 1'b1;
                                    shift_q  <= rd_word;
                                    rd_addr  <= addr_after(word_idx + 1'b1, len_q);
                                end else begin
                                    word_idx <= '0;
                                    if (!repeat_en) begin
                                        state <= ST_IDLE;
                                    end else if (gap_q == '0) begin
                                        shift_q <= rd_word;
                                        rd_addr <= addr_after('0, len_q);
                                    end else begin
                                        gap_cnt <= '0;
                                        state   <= ST_GAP;
                                    end
                                end
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == gap_q - 1'b1) begin
                        if (repeat_en) begin
                            shift_q <= rd_word;
                            rd_addr <= addr_after('0, len_q);
                            state   <= ST_SEND;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/manch_stream_gen_chk.sv
module manch_stream_gen_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [DIV_W-1:0] half_div,
    input logic             busy,
    input logic             ser_clk,
    input logic             ser_data
);

    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R1: lines and busy are idle right after a reset edge
    always @(negedge clk) begin
        if (rst_q) begin
            a_r1_idle_after_reset: assert (ser_clk && !ser_data && !busy)
                else $error("R1 idle levels after reset");
        end
    end

    // R1: no frame active means idle line levels
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ser_clk && !ser_data));

    // R3: every clock fall inside a frame carries a data transition
    a_r3_mid_bit_edge: assert property (@(posedge clk) disable iff (rst)
        (busy && $fell(ser_clk)) |-> (ser_data != $past(ser_data)));

    // R6: busy only rises after a start request
    a_r6_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R7: a zero divider never launches a frame
    a_r7_zero_div_ignored: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (half_div == '0)) |=> !busy);

endmodule

bind manch_stream_gen manch_stream_gen_chk #(
    .DIV_W (DIV_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .half_div (half_div),
    .busy     (busy),
    .ser_clk  (ser_clk),
    .ser_data (ser_data)
);

// File: tb/manch_stream_gen_bench.sv
`timescale 1ns/1ps
module manch_stream_gen_bench;

    localparam int WORD_W = 8;
    localparam int DEPTH  = 16;
    localparam int DIV_W  = 16;
    localparam int GAP_W  = 16;
    localparam int ADDR_W = 4;
    localparam int LEN_W  = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              start = 1'b0;
    logic              repeat_en = 1'b0;
    logic [LEN_W-1:0]  frame_len = '0;
    logic [DIV_W-1:0]  half_div = '0;
    logic [GAP_W-1:0]  gap_cycles = '0;
    logic              ser_clk;
    logic              ser_data;
    logic              busy;

    always #2.5 clk = ~clk;

    manch_stream_gen u_manch_stream_gen (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .start      (start),
        .repeat_en  (repeat_en),
        .frame_len  (frame_len),
        .half_div   (half_div),
        .gap_cycles (gap_cycles),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .busy       (busy)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cyc    = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] mem_m [DEPTH];
    int m_state = 0;   // 0 idle, 1 sending, 2 gap
    int t = 0, gc = 0, m_div = 1, m_len = 1, m_gap = 0, dec_cnt = 0;

    function automatic int frame_cycles();
        return m_len * 2 * WORD_W * m_div;
    endfunction

    function automatic int bit_at(input int n);
        int idx;
        idx = n % (m_len * WORD_W);
        return int'(mem_m[idx / WORD_W][WORD_W - 1 - (idx % WORD_W)]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0;
        end else begin
            if (wr_en) mem_m[wr_addr] = wr_data;
            case (m_state)
                0: if (start && frame_len != 0 && int'(frame_len) <= DEPTH && half_div != 0) begin
                    m_div = int'(half_div); m_len = int'(frame_len); m_gap = int'(gap_cycles);
                    t = 0; dec_cnt = 0; m_state = 1;
                end
                1: begin
                    t++;
                    if (t == frame_cycles()) begin
                        if (!repeat_en) m_state = 0;
                        else if (m_gap == 0) t = 0;
                        else begin gc = 0; m_state = 2; end
                    end
                end
                default: begin
                    gc++;
                    if (gc == m_gap) begin
                        if (repeat_en) begin t = 0; m_state = 1; end
                        else m_state = 0;
                    end
                end
            endcase
        end
    end

    // ---------------- per-cycle comparison and decoder ----------------
    logic prev_clk = 1'b1, prev_dat = 1'b0;

    always @(negedge clk) begin
        int e_clk, e_dat, e_busy, bitn, late, b, idx;
        string rq_c, rq_d;
        if (!rst && !done) begin
            e_clk = 1; e_dat = 0; e_busy = (m_state != 0);
            rq_c = (m_state == 0) ? "R1" : (m_state == 1) ? "R2" : "R9";
            rq_d = (m_state == 0) ? "R1" : (m_state == 1) ? "R3" : "R9";
            bitn = 0;
            if (m_state == 1) begin
                bitn  = t / (2 * m_div);
                late  = (t / m_div) % 2;
                b     = bit_at(bitn);
                e_clk = 1 - late;
                e_dat = b ^ late;
            end
            check(int'(ser_clk) == e_clk, rq_c, "clock line", int'(ser_clk), e_clk);
            check(int'(ser_data) == e_dat, rq_d, "data line", int'(ser_data), e_dat);
            check(int'(busy) == e_busy, "R6", "busy", int'(busy), e_busy);
            // decode: level just before the mid-bit clock fall is the bit
            if (busy && prev_clk && !ser_clk) begin
                idx = bit_at(dec_cnt);
                check(int'(prev_dat) == idx, "R5", "decoded bit", int'(prev_dat), idx);
                dec_cnt++;
            end
            // boundary edge only between equal bits
            if (m_state == 1 && !prev_clk && ser_clk) begin
                b = (bit_at(bitn) == bit_at(bitn + m_len * WORD_W - 1)) ? 1 : 0;
                check(int'(ser_data != prev_dat) == b, "R4", "boundary transition",
                      int'(ser_data != prev_dat), b);
            end
        end
        prev_clk = ser_clk;
        prev_dat = ser_data;
    end

    // ---------------- watchdog ----------------
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected 0 cycles over limit", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic write_word(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start(input int len, input int div, input int gap);
        @(negedge clk);
        frame_len = LEN_W'(len); half_div = DIV_W'(div); gap_cycles = GAP_W'(gap);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ser_clk && !ser_data && !busy, "R1", "idle after reset",
              int'({ser_clk, ser_data, busy}), 4);

        for (int i = 0; i < DEPTH; i++) write_word(i, 8'(i * 37 + 11));
        write_word(0, 8'h00); write_word(1, 8'hFF); write_word(2, 8'hA5);
        write_word(3, 8'h3C); write_word(4, 8'h96);
        repeat (2) @(negedge clk);

        // runs of equal bits and alternation, fastest divider
        pulse_start(3, 1, 0);
        wait_idle(n);
        check(n == 3 * 16 * 1, "R6", "busy length div1", n, 48);

        // slower divider, different words
        write_word(0, 8'h3C); write_word(1, 8'h96);
        repeat (2) @(negedge clk);
        pulse_start(2, 3, 0);
        wait_idle(n);
        check(n == 2 * 16 * 3, "R2", "busy length div3", n, 96);

        // R8 and R6: changes and a second start mid-frame are ignored
        pulse_start(2, 2, 0);
        repeat (10) @(negedge clk);
        frame_len = LEN_W'(1); half_div = DIV_W'(1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle(n);
        check(n + 11 == 2 * 16 * 2, "R8", "captured settings kept", n + 11, 64);

        // R7: invalid settings never start a frame
        pulse_start(0, 2, 0);
        check(!busy, "R7", "zero length ignored", int'(busy), 0);
        pulse_start(DEPTH + 1, 2, 0);
        check(!busy, "R7", "oversize length ignored", int'(busy), 0);
        pulse_start(2, 0, 0);
        check(!busy, "R7", "zero divider ignored", int'(busy), 0);

        // full memory frame
        pulse_start(DEPTH, 1, 0);
        wait_idle(n);
        check(n == DEPTH * 16, "R5", "full depth frame length", n, DEPTH * 16);

        // R9: repeat with an idle gap, then R10 stop
        repeat_en = 1'b1;
        pulse_start(1, 1, 5);
        repeat (60) @(negedge clk);
        check(busy, "R9", "busy held while repeating", int'(busy), 1);
        repeat_en = 1'b0;
        wait_idle(n);
        check(!busy, "R10", "returns idle after repeat off", int'(busy), 0);
        repeat (20) @(negedge clk);
        check(!busy && ser_clk && !ser_data, "R10", "stays idle",
              int'({ser_clk, ser_data, busy}), 4);

        // R9: back-to-back replay with a zero gap wraps to address 0
        repeat_en = 1'b1;
        pulse_start(2, 1, 0);
        repeat (100) @(negedge clk);
        repeat_en = 1'b0;
        wait_idle(n);
        check(!busy, "R10", "idle after zero-gap repeat", int'(busy), 0);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule